// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

This unit evaluates ordering relations, category tests and min/max selection on IEEE-754 binary32 or binary64 operands. A one-bit precision select picks the format: in single mode only the low 32 bits of each operand matter, in double mode all 64 bits do. The compare, unordered and classify operations return a predicate byte that is either all ones or all zeros, so a consumer can use it as a byte-wide lane mask.

Min and max return one of the two operands. They prefer numbers: when only one operand is NaN, the other operand wins. A NaN result is never passed through; it is replaced by an all-ones word of the active width. Double-precision min/max also signals an invalid-operation flag whenever a NaN is present.

The unit is combinational internally. Its three outputs are registered, so every result appears one clock after its inputs are presented.

Top module: `fpCmpUnit`

## Requirements
- R1: All three outputs are registered. They show the result for the inputs sampled at the previous rising clock edge. While `rstN` is low they are all zero.
- R2: Opcode encodings: 0 equal, 1 greater, 2 greater-or-equal, 3 unordered, 4 classify, 5 min, 6 max, 7 reserved. A true predicate is 8'hFF and a false one is 8'h00. The predicate ops (0 to 4) drive `result` to zero. Min/max and opcode 7 drive `pred` to zero, and opcode 7 also drives `result` and `invalid` to zero.
- R3: Equal, greater and greater-or-equal compare `opA` against `opB` quietly. If either operand is a NaN (signalling or quiet), they return false.
- R4: +0 and -0 are equal: equal and greater-or-equal are true, greater is false.
- R5: Unordered is true exactly when at least one operand is a NaN.
- R6: Classify tests `opA` against `classMask`: bit 0 zero, bit 1 normal, bit 2 subnormal, bit 3 infinity, bit 4 NaN. The predicate is true if any selected category matches.
- R7: Classify and the compare ops never assert `invalid`.
- R8: For non-NaN operands, min returns the numerically smaller operand and max the larger. When the two compare equal (including +0 against -0), `opA` is returned.
- R9: If exactly one operand of min/max is a NaN, the other operand is returned.
- R10: If both min/max operands are NaN, the result is all ones of the active width. In single mode that is 64'h0000_0000_FFFF_FFFF.
- R11: `invalid` is set for double-precision min/max whenever either operand is a NaN. It is never set by single-precision min/max.
- R12: When `isDouble` is 0, bits 63:32 of both operands are ignored, and single-precision results carry zero in bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opSel | input | 3 | Operation code |
| isDouble | input | 1 | 1 selects binary64, 0 selects binary32 in the low 32 bits |
| classMask | input | 5 | Category select for classify |
| pred | output | 8 | Registered predicate byte |
| result | output | 64 | Registered min/max result |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
On every cycle, the embedded assertions check the following:
- The opcode decode yields at most one operation.
- A NaN operand forces the ordered compares false and the unordered test true one cycle later.
- Classify never raises `invalid`.
- Double-precision min/max with a NaN input does raise `invalid`.
- Two NaN inputs to min/max produce the canonical all-ones word.

Only the bench's scenarios show that the numeric ordering is correct:
- signed zeros treated as equal;
- subnormals ordered against normals;
- infinities ordered against finite values;
- the tie rule that returns `opA`;
- number preference when one operand is NaN;
- the per-bit category selection of classify;
- immunity to garbage in the upper word in single mode.

// File: rtl/fpCmpPkg.sv
package fpCmpPkg;
  localparam int OPW    = 64;
  localparam int SPW    = 32;
  localparam int EXPD   = 11;
  localparam int MANTD  = 52;
  localparam int EXPS   = 8;
  localparam int MANTS  = 23;
  localparam int CLSW   = 5;
  localparam int PREDW  = 8;
  localparam int KEYW   = OPW + 1;

  typedef enum logic [2:0] {
    OP_EQ    = 3'd0,
    OP_GT    = 3'd1,
    OP_GE    = 3'd2,
    OP_UO    = 3'd3,
    OP_CLASS = 3'd4,
    OP_MIN   = 3'd5,
    OP_MAX   = 3'd6,
    OP_RSVD  = 3'd7
  } fpOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic isDouble;
    logic doEq;
    logic doGt;
    logic doGe;
    logic doUo;
    logic doClass;
    logic doMin;
    logic doMax;
  } cmpStrobe_t;

  // per-operand category flags and an ordering key
  typedef struct packed {
    logic            isZero;
    logic            isNormal;
    logic            isDenorm;
    logic            isInf;
    logic            isNan;
    logic [KEYW-1:0] key;
  } opClass_t;
endpackage

// File: rtl/fpOperandClass.sv
module fpOperandClass
  import fpCmpPkg::*;
(
  input  logic [OPW-1:0] opnd,
  input  logic           isDouble,
  output opClass_t       cls
);
  logic            sign;
  logic            expAllOne;
  logic            expZero;
  logic            mantZero;
  logic [OPW-1:0]  mag;

  always_comb begin
    if (isDouble) begin
      sign      = opnd[OPW-1];
      expAllOne = &opnd[MANTD +: EXPD];
      expZero   = ~|opnd[MANTD +: EXPD];
      mantZero  = ~|opnd[MANTD-1:0];
      mag       = {1'b0, opnd[OPW-2:0]};
    end else begin
      sign      = opnd[SPW-1];
      expAllOne = &opnd[MANTS +: EXPS];
      expZero   = ~|opnd[MANTS +: EXPS];
      mantZero  = ~|opnd[MANTS-1:0];
      mag       = {{(OPW-SPW+1){1'b0}}, opnd[SPW-2:0]};
    end
    cls.isZero   = expZero & mantZero;
    cls.isDenorm = expZero & ~mantZero;
    cls.isNormal = ~expZero & ~expAllOne;
    cls.isInf    = expAllOne & mantZero;
    cls.isNan    = expAllOne & ~mantZero;
    // monotone key: negatives invert magnitude and sit below positives
    cls.key      = sign ? {1'b0, ~mag} : {1'b1, mag};
  end
endmodule

// File: rtl/fpCmpCtrl.sv
module fpCmpCtrl
  import fpCmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opSel,
  input  logic       isDouble,
  output cmpStrobe_t strb
);
  fpOp_e opCode;

  always_comb begin
    opCode        = fpOp_e'(opSel);
    strb          = '0;
    strb.isDouble = isDouble;
    unique case (opCode)
      OP_EQ:    strb.doEq    = 1'b1;
      OP_GT:    strb.doGt    = 1'b1;
      OP_GE:    strb.doGe    = 1'b1;
      OP_UO:    strb.doUo    = 1'b1;
      OP_CLASS: strb.doClass = 1'b1;
      OP_MIN:   strb.doMin   = 1'b1;
      OP_MAX:   strb.doMax   = 1'b1;
      default:  ;
    endcase
  end

  // R2
  one_op_decoded_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doEq, strb.doGt, strb.doGe, strb.doUo,
              strb.doClass, strb.doMin, strb.doMax}));
endmodule

// File: rtl/fpCmpDatapath.sv
module fpCmpDatapath
  import fpCmpPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t       strb,
  input  logic [OPW-1:0]   opA,
  input  logic [OPW-1:0]   opB,
  input  logic [CLSW-1:0]  classMask,
  output logic [PREDW-1:0] predQ,
  output logic [OPW-1:0]   resultQ,
  output logic             invalidQ
);
  localparam int NOPS = 2;

  logic [OPW-1:0] opnds [NOPS];
  opClass_t       cls   [NOPS];

  assign opnds[0] = opA;
  assign opnds[1] = opB;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fpOperandClass u_cls (
      .opnd     (opnds[gi]),
      .isDouble (strb.isDouble),
      .cls      (cls[gi])
    );
  end

  logic           anyNan, bothNan, bothZero;
  logic           aEqB, aGtB, bGtA;
  logic           classHit, predBit;
  logic [OPW-1:0] aNarrow, bNarrow, nanWord, minVal, maxVal;
  logic [PREDW-1:0] predD;
  logic [OPW-1:0]   resultD;
  logic             invalidD;

  always_comb begin
    anyNan   = cls[0].isNan | cls[1].isNan;
    bothNan  = cls[0].isNan & cls[1].isNan;
    bothZero = cls[0].isZero & cls[1].isZero;
    aEqB     = ~anyNan & (bothZero | (cls[0].key == cls[1].key));
    aGtB     = ~anyNan & ~bothZero & (cls[0].key > cls[1].key);
    bGtA     = ~anyNan & ~bothZero & (cls[1].key > cls[0].key);
    classHit = |(classMask & {cls[0].isNan, cls[0].isInf, cls[0].isDenorm,
                              cls[0].isNormal, cls[0].isZero});

    predBit  = (strb.doEq    & aEqB)
             | (strb.doGt    & aGtB)
             | (strb.doGe    & (aGtB | aEqB))
             | (strb.doUo    & anyNan)
             | (strb.doClass & classHit);
    predD    = {PREDW{predBit}};

    if (strb.isDouble) begin
      aNarrow = opA;
      bNarrow = opB;
      nanWord = '1;
    end else begin
      aNarrow = {{(OPW-SPW){1'b0}}, opA[SPW-1:0]};
      bNarrow = {{(OPW-SPW){1'b0}}, opB[SPW-1:0]};
      nanWord = {{(OPW-SPW){1'b0}}, {SPW{1'b1}}};
    end

    if (bothNan)            minVal = nanWord;
    else if (cls[0].isNan)  minVal = bNarrow;
    else if (cls[1].isNan)  minVal = aNarrow;
    else if (aGtB)          minVal = bNarrow;
    else                    minVal = aNarrow;

    if (bothNan)            maxVal = nanWord;
    else if (cls[0].isNan)  maxVal = bNarrow;
    else if (cls[1].isNan)  maxVal = aNarrow;
    else if (bGtA)          maxVal = bNarrow;
    else                    maxVal = aNarrow;

    resultD  = strb.doMin ? minVal : (strb.doMax ? maxVal : '0);
    invalidD = strb.isDouble & (strb.doMin | strb.doMax) & anyNan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predQ    <= '0;
      resultQ  <= '0;
      invalidQ <= 1'b0;
    end else begin
      predQ    <= predD;
      resultQ  <= resultD;
      invalidQ <= invalidD;
    end
  end

  // R3
  nan_cmp_false_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.doEq | strb.doGt | strb.doGe) & (cls[0].isNan | cls[1].isNan))
      |=> (predQ == 8'h00));

  // R5
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doUo & (cls[0].isNan | cls[1].isNan)) |=> (predQ == 8'hFF));

  // R7
  class_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doClass |=> !invalidQ);

  // R11
  dbl_nan_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isDouble & (strb.doMin | strb.doMax) & (cls[0].isNan | cls[1].isNan))
      |=> invalidQ);

  // R10
  both_nan_canon_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.doMin | strb.doMax) & cls[0].isNan & cls[1].isNan)
      |=> (resultQ[SPW-1:0] == {SPW{1'b1}}));
endmodule

// File: rtl/fpCmpUnit.sv
module fpCmpUnit
  import fpCmpPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPW-1:0]   opA,
  input  logic [OPW-1:0]   opB,
  input  logic [2:0]       opSel,
  input  logic             isDouble,
  input  logic [CLSW-1:0]  classMask,
  output logic [PREDW-1:0] pred,
  output logic [OPW-1:0]   result,
  output logic             invalid
);
  cmpStrobe_t strb;

  fpCmpCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opSel    (opSel),
    .isDouble (isDouble),
    .strb     (strb)
  );

  fpCmpDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .classMask (classMask),
    .predQ     (pred),
    .resultQ   (result),
    .invalidQ  (invalid)
  );
endmodule

// File: tb/test_fpCmpUnit.sv
`timescale 1ns/1ps
module test_fpCmpUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [2:0]  opSel = '0;
  logic        isDouble = 1'b0;
  logic [4:0]  classMask = '0;
  logic [7:0]  pred;
  logic [63:0] result;
  logic        invalid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fpCmpUnit i_fpCmpUnit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .isDouble(isDouble), .classMask(classMask),
    .pred(pred), .result(result), .invalid(invalid)
  );

  function automatic bit isNanOf(logic [63:0] v, bit dbl);
    if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic real valOf(logic [63:0] v, bit dbl);
    real r;
    int  e;
    if (dbl) return $bitstoreal(v);
    e = int'(v[30:23]);
    if (e == 0) begin
      r = real'(v[22:0]) * (2.0 ** (-149));
      return v[31] ? -r : r;
    end
    if (e == 255) return $bitstoreal({v[31], 11'h7FF, 52'h0});
    return $bitstoreal({v[31], 11'(e - 127 + 1023), v[22:0], 29'h0});
  endfunction

  function automatic logic [4:0] catsOf(logic [63:0] v, bit dbl);
    int e, emax;
    bit mz;
    e    = dbl ? int'(v[62:52]) : int'(v[30:23]);
    emax = dbl ? 2047 : 255;
    mz   = dbl ? (v[51:0] == 0) : (v[22:0] == 0);
    // bit0 zero, bit1 normal, bit2 subnormal, bit3 inf, bit4 nan
    return {(e == emax) && !mz, (e == emax) && mz, (e == 0) && !mz,
            (e != 0) && (e != emax), (e == 0) && mz};
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] op, input bit dbl, input logic [4:0] m,
                       output logic [7:0] ep, output logic [63:0] er, output bit ei);
    bit  na, nb, t;
    real ra, rb;
    logic [63:0] aw, bw, ones;
    na = isNanOf(a, dbl); nb = isNanOf(b, dbl);
    ra = valOf(a, dbl);   rb = valOf(b, dbl);
    aw = dbl ? a : {32'h0, a[31:0]};
    bw = dbl ? b : {32'h0, b[31:0]};
    ones = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    ep = 8'h00; er = 64'h0; ei = 1'b0; t = 1'b0;
    case (op)
      3'd0: t = !na && !nb && (ra == rb);
      3'd1: t = !na && !nb && (ra >  rb);
      3'd2: t = !na && !nb && (ra >= rb);
      3'd3: t = na || nb;
      3'd4: t = (catsOf(a, dbl) & m) != 0;
      3'd5, 3'd6: begin
        if (na && nb) er = ones;
        else if (na)  er = bw;
        else if (nb)  er = aw;
        else if (op == 3'd5) er = (rb < ra) ? bw : aw;
        else                 er = (rb > ra) ? bw : aw;
        ei = dbl && (na || nb);
      end
      default: ;
    endcase
    if (t) ep = 8'hFF;
  endtask

  task automatic step(input logic [63:0] a, input logic [63:0] b,
                      input logic [2:0] op, input bit dbl, input logic [4:0] m,
                      input string tag);
    logic [7:0] ep; logic [63:0] er; bit ei;
    opA = a; opB = b; opSel = op; isDouble = dbl; classMask = m;
    model(a, b, op, dbl, m, ep, er, ei);
    @(negedge clk);
    nChecks++;
    if (pred !== ep || result !== er || invalid !== ei) begin
      nFails++;
      $display("FAIL %s op=%0d dbl=%0d a=%h b=%h: pred=%h res=%h inv=%0d expected pred=%h res=%h inv=%0d",
               tag, op, dbl, a, b, pred, result, invalid, ep, er, ei);
    end
  endtask

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  logic [31:0] sp [11] = '{32'h3F800000, 32'h40000000, 32'hBF800000, 32'h00000000,
                           32'h80000000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
                           32'h7F800001, 32'h00000001, 32'h7F7FFFFF};
  logic [63:0] dp [9]  = '{64'h3FF0000000000000, 64'h4000000000000000, 64'hC000000000000000,
                           64'h0, 64'h8000000000000000, 64'h7FF0000000000000,
                           64'h7FF8000000000000, 64'h1, 64'h7FF0000000000001};

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    opA = 64'h3F800000; opB = 64'h0; opSel = 3'd6; isDouble = 1'b0; classMask = 5'h1F;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    nChecks++;
    if (pred !== 8'h0 || result !== 64'h0 || invalid !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset pred=%h res=%h inv=%0d expected 00/0/0", pred, result, invalid);
    end
    rstN = 1'b1;

    step(64'h3F800000, 64'h40000000, 3'd1, 0, 0, "R1");
    step(64'h40000000, 64'h3F800000, 3'd1, 0, 0, "R3");
    step(64'h3F800000, 64'h3F800000, 3'd0, 0, 0, "R3");
    step(64'h7F800001, 64'h7F800001, 3'd0, 0, 0, "R3");
    step(64'h7FC00000, 64'h3F800000, 3'd2, 0, 0, "R3");
    step(64'h0, 64'h80000000, 3'd0, 0, 0, "R4");
    step(64'h0, 64'h80000000, 3'd1, 0, 0, "R4");
    step(64'h8000000000000000, 64'h0, 3'd2, 1, 0, "R4");
    step(64'h7FF8000000000000, 64'h0, 3'd3, 1, 0, "R5");
    step(64'h3FF0000000000000, 64'h0, 3'd3, 1, 0, "R5");
    step(64'h00000001, 64'h0, 3'd4, 0, 5'b00100, "R6");
    step(64'h00000001, 64'h0, 3'd4, 0, 5'b11011, "R6");
    step(64'h7FF0000000000000, 64'h0, 3'd4, 1, 5'b01000, "R6");
    step(64'h7FF8000000000000, 64'h0, 3'd4, 1, 5'b10000, "R7");
    step(64'h3F800000, 64'hBF800000, 3'd5, 0, 0, "R8");
    step(64'h0, 64'h80000000, 3'd5, 0, 0, "R8");
    step(64'h80000000, 64'h0, 3'd6, 0, 0, "R8");
    step(64'h7FC00000, 64'h40000000, 3'd6, 0, 0, "R9");
    step(64'h4000000000000000, 64'h7FF8000000000000, 3'd5, 1, 0, "R9");
    step(64'h7FC00000, 64'h7F800001, 3'd5, 0, 0, "R10");
    step(64'h7FF8000000000000, 64'h7FF0000000000001, 3'd6, 1, 0, "R10");
    step(64'h3FF0000000000000, 64'h7FF8000000000000, 3'd6, 1, 0, "R11");
    step(64'h7FC00000, 64'h7FC00000, 3'd6, 0, 0, "R11");
    step(64'hDEADBEEF3F800000, 64'h1234567840000000, 3'd6, 0, 0, "R12");
    step(64'hFFFFFFFF00000000, 64'h0000000080000000, 3'd0, 0, 0, "R12");
    step(64'h7FF8000000000000, 64'h7FF8000000000000, 3'd7, 1, 5'h1F, "R2");

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a, b;
      logic [2:0]  op;
      bit dbl;
      dbl = $urandom_range(0, 1);
      op  = 3'($urandom_range(0, 7));
      if (dbl) begin
        a = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : dp[$urandom_range(0, 8)];
        b = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : dp[$urandom_range(0, 8)];
      end else begin
        a = {$urandom, (($urandom_range(0, 3) == 0) ? $urandom : sp[$urandom_range(0, 10)])};
        b = {$urandom, (($urandom_range(0, 3) == 0) ? $urandom : sp[$urandom_range(0, 10)])};
      end
      step(a, b, op, dbl, 5'($urandom_range(0, 31)), tagOf(op));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule